// File: doc/BRIEF.md
# SD/MMC Host Interrupt Status and Mask Unit

This block gathers the event sources of an SD/MMC host controller into one 16-bit status word that software reads, and combines it with a 16-bit mask into a single interrupt request line. Four sources are sticky: a card-signalled SDIO interrupt, command-response completion, programming completion and data-transfer completion. Each is captured on the rising edge of a pulse from its producer and held until software clears it. The other two sources are the transmit-FIFO write request and the receive-FIFO read request. They are level signals that mirror the FIFO threshold conditions and are never latched.

Software writes the mask word to choose which status bits may raise the interrupt line. A mask bit at 1 blocks its source. Software writes the status word with ones to acknowledge sticky events. Status bits are always readable, so a masked event can still be polled.

Top module: `sdmmc_irq_status`

## Requirements
- R1: Status bit map: bit 7 SDIO card interrupt, bit 6 transmit FIFO write request, bit 5 receive FIFO read request, bit 2 command response ended, bit 1 programming done, bit 0 data transfer done.
- R2: A mask bit of 1 blocks that status bit from the interrupt line. The mask resets to 0xFFFF. A mask write loads all 16 bits of `wr_data_i`, visible after the next clock edge.
- R3: A status write clears each sticky bit (0, 1, 2, 7) whose data bit is 1 and leaves the sticky bits whose data bit is 0 unchanged, effective after the next clock edge.
- R4: Status bits show their events whatever the mask holds.
- R5: Bits 6 and 5 follow `tx_req_i` and `rx_req_i` combinationally, and a status write has no effect on them.
- R6: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0, with no added register.
- R7: When an event rises in the same cycle as a status write that clears its bit, the bit is set after that edge.
- R8: Bits 3, 4 and 8 to 15 of the status word always read 0, and status writes to them have no effect.
- R9: A sticky bit is set one edge after its event input rises from 0 to 1. An event input that stays high does not set the bit again.
- R10: Synchronous reset (active low) clears all sticky bits and the event edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sdio_evt_i | input | 1 | SDIO card interrupt event pulse |
| cmd_resp_evt_i | input | 1 | Command response ended event pulse |
| prog_done_evt_i | input | 1 | Programming done event pulse |
| xfer_done_evt_i | input | 1 | Data transfer done event pulse |
| tx_req_i | input | 1 | Transmit FIFO write request level |
| rx_req_i | input | 1 | Receive FIFO read request level |
| stat_wr_i | input | 1 | Write-one-to-clear strobe for the status word |
| mask_wr_i | input | 1 | Load strobe for the mask word |
| wr_data_i | input | 16 | Write data for either strobe |
| status_o | output | 16 | Status word |
| mask_o | output | 16 | Mask word |
| irq_o | output | 1 | Interrupt request line |

## Verification
An event pulse or a status or mask write presented in cycle k shows up at the outputs just after clock edge k, because it passes through exactly one register. The level FIFO bits and `irq_o` are combinational from the current status, mask and level inputs. The bench drives every vector at the falling edge, lets exactly one rising edge pass, and samples 1 ns later. At that point both the registered results of the vector and the combinational results of its still-driven level inputs are settled. Each vector lasts one cycle, so an event bit that stays high across consecutive vectors models a held input for the single-set check.

// File: rtl/sdmmc_irq_pkg.sv
`timescale 1ns/1ps
// Package: widths and bit positions shared by the interrupt status unit.
// Assumes a 16-bit register word. The bit positions are fixed because
// software decodes them.
package sdmmc_irq_pkg;
    localparam int REG_W      = 16;
    localparam int NUM_STICKY = 4;

    // Status bit positions.
    localparam int POS_XFER_DONE = 0;
    localparam int POS_PROG_DONE = 1;
    localparam int POS_CMD_RESP  = 2;
    localparam int POS_RX_REQ    = 5;
    localparam int POS_TX_REQ    = 6;
    localparam int POS_SDIO      = 7;

    // Sticky source index to status bit position.
    localparam int STICKY_POS [NUM_STICKY] = '{POS_XFER_DONE, POS_PROG_DONE,
                                               POS_CMD_RESP, POS_SDIO};
endpackage

// File: rtl/sdmmc_irq_edge.sv
`timescale 1ns/1ps
// Module: rising-edge detector for a bundle of event inputs.
// Assumes the inputs are synchronous to clk. A rise in cycle k is
// reported combinationally in cycle k.
module sdmmc_irq_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] evt_q;

    // Keep last cycle's event levels.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_i;
    end

    // Flag a 0 to 1 transition.
    always_comb rise_o = evt_i & ~evt_q;

    // A rise is reported only when the input was low one cycle earlier (R9).
    assert_rise_needs_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o[0] |=> !rise_o[0] || !$past(evt_i[0]) );
endmodule

// File: rtl/sdmmc_irq_sticky.sv
`timescale 1ns/1ps
// Module: one sticky status bit with write-one-to-clear.
// Assumes set_i is a single-cycle rise flag. When set and clear
// coincide, set wins.
module sdmmc_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Hold, set or clear the event bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/sdmmc_irq_mask.sv
`timescale 1ns/1ps
// Module: interrupt mask register. It resets to all ones, which blocks
// every source. A write loads the whole word.
module sdmmc_irq_mask #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);
    // Load or hold the mask word.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_o <= '1;
        else if (we_i) mask_o <= wdata_i;
    end

    assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mask_o == $past(wdata_i));
    assert_mask_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> mask_o == '1);
endmodule

// File: rtl/sdmmc_irq_status.sv
`timescale 1ns/1ps
// Module: SD/MMC host interrupt status and mask unit (top).
// It combines sticky event bits, level FIFO request bits and a mask word
// into a status word and one interrupt line. Assumes all inputs are
// synchronous to clk.
module sdmmc_irq_status
    import sdmmc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdio_evt_i,
    input  logic             cmd_resp_evt_i,
    input  logic             prog_done_evt_i,
    input  logic             xfer_done_evt_i,
    input  logic             tx_req_i,
    input  logic             rx_req_i,
    input  logic             stat_wr_i,
    input  logic             mask_wr_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] mask_o,
    output logic             irq_o
);
    logic [NUM_STICKY-1:0] evt_bus;
    logic [NUM_STICKY-1:0] evt_rise;
    logic [NUM_STICKY-1:0] sticky_q;

    // Order the event inputs by sticky source index.
    always_comb evt_bus = {sdio_evt_i, cmd_resp_evt_i, prog_done_evt_i, xfer_done_evt_i};

    sdmmc_irq_edge #(.N(NUM_STICKY)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_bus),
        .rise_o (evt_rise)
    );

    for (genvar g = 0; g < NUM_STICKY; g++) begin : g_sticky
        sdmmc_irq_sticky u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_rise[g]),
            .clr_i (stat_wr_i && wr_data_i[STICKY_POS[g]]),
            .q_o   (sticky_q[g])
        );
    end

    sdmmc_irq_mask #(.W(REG_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mask_wr_i),
        .wdata_i (wr_data_i),
        .mask_o  (mask_o)
    );

    // Assemble the status word. Unlisted bits read zero.
    always_comb begin
        status_o             = '0;
        status_o[POS_TX_REQ] = tx_req_i;
        status_o[POS_RX_REQ] = rx_req_i;
        for (int s = 0; s < NUM_STICKY; s++) status_o[STICKY_POS[s]] = sticky_q[s];
    end

    // Drive the interrupt from unmasked status bits.
    always_comb irq_o = |(status_o & ~mask_o);

    assert_all_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '1) |-> !irq_o);
    assert_rx_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_req_i) |-> status_o[POS_RX_REQ]);
endmodule

// File: tb/sdmmc_irq_status_bench.sv
`timescale 1ns/1ps
module sdmmc_irq_status_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sdio, cmd, prog, xfer, tx, rx, swe, mwe;
    logic [15:0] wdata;
    logic [15:0] status, mask;
    logic irq;
    int vec_cnt = 0;
    int err_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdmmc_irq_status u_sdmmc_irq_status (
        .clk(clk), .rst_n(rst_n),
        .sdio_evt_i(sdio), .cmd_resp_evt_i(cmd), .prog_done_evt_i(prog),
        .xfer_done_evt_i(xfer), .tx_req_i(tx), .rx_req_i(rx),
        .stat_wr_i(swe), .mask_wr_i(mwe), .wr_data_i(wdata),
        .status_o(status), .mask_o(mask), .irq_o(irq)
    );

    // Vector: {sdio,cmd,prog,xfer}[40:37] {tx,rx}[36:35] swe[34] mwe[33]
    //         wdata[32:17] exp_status[16:1] exp_irq[0]
    localparam int NV = 17;
    localparam logic [40:0] VEC [NV] = '{
        {4'b0001, 2'b00, 1'b0, 1'b0, 16'h0000, 16'h0001, 1'b0}, // R4 masked event visible
        {4'b0000, 2'b00, 1'b0, 1'b1, 16'hFFFE, 16'h0001, 1'b1}, // R6 unmask bit 0
        {4'b1000, 2'b00, 1'b0, 1'b0, 16'h0000, 16'h0081, 1'b1}, // R1 sdio at bit 7
        {4'b0000, 2'b00, 1'b1, 1'b0, 16'h0001, 16'h0080, 1'b0}, // R3 clear bit 0 only
        {4'b0000, 2'b00, 1'b0, 1'b1, 16'hFF7F, 16'h0080, 1'b1}, // R2 unmask bit 7
        {4'b0000, 2'b10, 1'b0, 1'b0, 16'h0000, 16'h00C0, 1'b1}, // R5 tx level bit 6
        {4'b0000, 2'b10, 1'b1, 1'b0, 16'hFFFF, 16'h0040, 1'b0}, // R8 clear-all keeps level
        {4'b0000, 2'b10, 1'b0, 1'b1, 16'hFFBF, 16'h0040, 1'b1}, // R6 unmask bit 6
        {4'b0000, 2'b01, 1'b0, 1'b0, 16'h0000, 16'h0020, 1'b0}, // R5 rx level bit 5
        {4'b0100, 2'b00, 1'b1, 1'b0, 16'h0004, 16'h0004, 1'b0}, // R7 event beats clear
        {4'b0100, 2'b00, 1'b1, 1'b0, 16'h0004, 16'h0000, 1'b0}, // R9 held, clear works
        {4'b0100, 2'b00, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0}, // R9 held, no re-set
        {4'b0000, 2'b00, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0}, // R9 drop
        {4'b0100, 2'b00, 1'b0, 1'b0, 16'h0000, 16'h0004, 1'b0}, // R9 new rise sets
        {4'b0010, 2'b00, 1'b0, 1'b1, 16'h0000, 16'h0006, 1'b1}, // R1 prog at bit 1
        {4'b0000, 2'b00, 1'b1, 1'b0, 16'h0018, 16'h0006, 1'b1}, // R8 bits 3,4 no effect
        {4'b0000, 2'b00, 1'b1, 1'b0, 16'h0006, 16'h0000, 1'b0}  // R3 clear bits 1,2
    };

    function automatic string req_of(int i);
        case (i)
            0: return "R4";  1: return "R6";  2: return "R1";  3: return "R3";
            4: return "R2";  5: return "R5";  6: return "R8";  7: return "R6";
            8: return "R5";  9: return "R7";  14: return "R1"; 15: return "R8";
            16: return "R3";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            err_cnt++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        {sdio, cmd, prog, xfer, tx, rx, swe, mwe} = '0;
        wdata = '0;
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1;
        check("R10", status, 16'h0000);   // reset state
        check("R2", mask, 16'hFFFF);
        check("R6", {15'd0, irq}, 16'd0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {sdio, cmd, prog, xfer} = VEC[i][40:37];
            {tx, rx} = VEC[i][36:35];
            swe = VEC[i][34];
            mwe = VEC[i][33];
            wdata = VEC[i][32:17];
            @(posedge clk);
            #1;
            check(req_of(i), status, VEC[i][16:1]);
            check(req_of(i), {15'd0, irq}, {15'd0, VEC[i][0]});
        end
        check("R2", mask, 16'h0000);

        // R5: level bit follows the input within the same cycle.
        @(negedge clk);
        idle();
        rx = 1'b1;
        #1 check("R5", status, 16'h0020);
        check("R6", {15'd0, irq}, 16'd1);

        // R10: reset clears sticky bits and restores the mask.
        @(negedge clk);
        idle();
        xfer = 1'b1;
        @(negedge clk);
        idle();
        check("R1", status, 16'h0001);
        rst_n = 1'b0;
        @(posedge clk);
        #1 check("R10", status, 16'h0000);
        check("R2", mask, 16'hFFFF);
        @(negedge clk) rst_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            vec_cnt++;
            err_cnt++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
            $finish;
        end
    end
endmodule